// File: doc/BRIEF.md
# Interlocked Handshake Debug Register Target

This block is the target end of a debug module interface. It answers read and write requests through a fully interlocked request/acknowledge handshake. A master, such as a scan-chain controller, raises a request together with a write-enable flag, an address and write data. The target captures all of them in the cycle it accepts the request. It answers by raising acknowledge, and for reads it also presents the read data. Acknowledge and read data stay put until the master drops request. After that the master must leave request low for one cycle past the fall of acknowledge.

Behind the handshake sits a small bank of data registers, indexed by the low part of the address. Addresses past the end of the bank are acknowledged like any other. Reads of them return zero and writes to them are dropped. A sticky flag records the case where the master raises request in the cycle right after acknowledge fell, which breaks the one-cycle rule.

Top module: `dmi_tgt`

## Requirements
- R1: With acknowledge low and the target idle, request high in a cycle is accepted at that clock edge, and acknowledge is high from that edge on.
- R2: Acknowledge stays high on every edge at which request is still high. It falls at the first edge at which request is seen low.
- R3: For a read, rdata_o carries the addressed register's value from the edge that raises acknowledge. It holds unchanged while acknowledge is high and after it falls, until the next acceptance. An accepted write loads zero into rdata_o.
- R4: A write updates the addressed register exactly once, at acceptance. Holding request high for further cycles never writes again, even if the write data changes.
- R5: Address, write data and write-enable are taken only at acceptance. Changing them while acknowledge is high does not change the read data, does not start a write and does not alter any register.
- R6: The bank holds NUM_REGS registers (16 by default) at addresses 0 to NUM_REGS-1. A read of any higher address is acknowledged and returns zero. A write to a higher address is acknowledged and changes no register, and no aliasing into the bank occurs.
- R7: Request high in the cycle right after acknowledge fell sets proto_err_o, and that request is not accepted in that cycle. If request is still high the next cycle, it is accepted then. proto_err_o stays high until reset and stays low under compliant traffic.
- R8: While rst_ni is low, acknowledge is low, rdata_o is zero, proto_err_o is low and every register reads back as zero once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by master and target |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request level from the master |
| we_i | input | 1 | 1 = write, 0 = read; valid with request |
| addr_i | input | ADDR_W (8) | Register address, valid with request |
| wdata_i | input | DATA_W (64) | Write data, valid with request |
| ack_o | output | 1 | Acknowledge level |
| rdata_o | output | DATA_W (64) | Read data, held while acknowledged |
| proto_err_o | output | 1 | Sticky handshake-violation flag |

## Verification
Two functions can fall in the same cycle: flagging a protocol violation and taking a new request. Both happen when request is high in the cycle right after acknowledge has dropped. The bench provokes this on purpose. It checks that the flag rises at once and that acknowledge stays low for that cycle, and that the request is then taken one cycle later with the correct read data. Around this case, long runs of random reads and writes, with address, data and write-enable scrambled during the hold, are compared against a register model kept by the bench.

// File: rtl/dmi_tgt_pkg.sv
package dmi_tgt_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_ACK  = 2'd1,
    HS_GAP  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/dmi_tgt_hs.sv
module dmi_tgt_hs
  import dmi_tgt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic accept_o,
  output logic ack_o,
  output logic err_o
);
  hs_state_e state_q, state_d;
  logic      err_q, err_set;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    err_set  = 1'b0;
    case (state_q)
      HS_IDLE: if (req_i) begin
        accept_o = 1'b1;
        state_d  = HS_ACK;
      end
      HS_ACK:  if (!req_i) state_d = HS_GAP;
      HS_GAP: begin
        // mandatory quiet cycle after ack falls
        err_set = req_i;
        state_d = HS_IDLE;
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (err_set) err_q <= 1'b1;
    end
  end

  assign ack_o = (state_q == HS_ACK);
  assign err_o = err_q;

  a_r1_ack_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_IDLE && req_i) |=> ack_o);
  a_r2_ack_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && req_i) |=> ack_o);
  a_r2_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !req_i) |=> !ack_o);
  a_r4_single_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);
  a_r7_gap_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_GAP) |=> !ack_o);
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/dmi_tgt_regbank.sv
module dmi_tgt_regbank #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int              IDX_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] sel;
  logic                hit;
  logic [IDX_W-1:0]    idx;

  assign hit = (addr_i <= LAST);
  assign idx = addr_i[IDX_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel[g] = wr_en_i && hit && (idx == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (sel[i]) regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) rdata_o = regs_q[idx];
  end

  a_r4_one_hot_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
  a_r6_oob_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> $stable(regs_q[0]));
endmodule

// File: rtl/dmi_tgt.sv
module dmi_tgt #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              proto_err_o
);
  logic              accept;
  logic [DATA_W-1:0] bank_rdata;
  logic [DATA_W-1:0] rdata_q;

  dmi_tgt_hs u_hs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .accept_o(accept),
    .ack_o   (ack_o),
    .err_o   (proto_err_o)
  );

  dmi_tgt_regbank #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(accept && we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(bank_rdata)
  );

  // response captured once per handshake, held until next acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (accept) rdata_q <= we_i ? '0 : bank_rdata;
  end

  assign rdata_o = rdata_q;

  a_r3_rdata_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> (!ack_o || $stable(rdata_o)));
  a_r5_no_capture_in_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !accept) |=> $stable(rdata_o));
endmodule

// File: tb/dmi_tgt_test.sv
module dmi_tgt_test;
  localparam int AW = 8;
  localparam int DW = 64;
  localparam int NR = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ack, err;
  logic [DW-1:0] rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [NR];

  always #10 clk = ~clk;

  dmi_tgt #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .proto_err_o(err)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_rd(input logic w, input logic [AW-1:0] a);
    if (w) return '0;
    return (a < AW'(NR)) ? model[a[3:0]] : '0;
  endfunction

  // full compliant transaction; returns with target idle, at a negedge
  task automatic txn(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input int hold, input bit scramble);
    logic [DW-1:0] exp;
    exp = expect_rd(w, a);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    chk("R1 ack after accept", {63'd0, ack}, 64'd1);
    chk(w ? "R3 write gives zero rdata" : "R3 read data", rdata, exp);
    if (w && a < AW'(NR)) model[a[3:0]] = d;
    for (int h = 0; h < hold; h++) begin
      if (scramble) begin
        we = $urandom_range(0, 1) == 1;
        addr = AW'($urandom_range(0, 31));
        wdata = {$urandom, $urandom};
      end
      @(negedge clk);
      chk("R2 ack held with req", {63'd0, ack}, 64'd1);
      chk("R5 rdata stable in hold", rdata, exp);
    end
    req = 1'b0;
    @(negedge clk);
    chk("R2 ack falls after req low", {63'd0, ack}, 64'd0);
    chk("R3 rdata kept after ack", rdata, exp);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) model[i] = '0;
    @(negedge clk);
    chk("R8 ack in reset", {63'd0, ack}, 64'd0);
    chk("R8 rdata in reset", rdata, 64'd0);
    chk("R8 err in reset", {63'd0, err}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: bank reads back zero
    for (int i = 0; i < NR; i++) txn(1'b0, AW'(i), '0, 0, 1'b0);

    // R4/R5: write with data scrambled during a long hold
    txn(1'b1, 8'd5, 64'hDEAD_BEEF_0123_4567, 4, 1'b1);
    txn(1'b0, 8'd5, '0, 0, 1'b0);
    chk("R4 single write value", rdata, 64'hDEAD_BEEF_0123_4567);

    // R6: out-of-range write must not alias into register 0
    txn(1'b1, 8'd0, 64'h1111, 0, 1'b0);
    txn(1'b1, 8'd16, 64'h2222, 1, 1'b0);
    txn(1'b1, 8'd255, 64'h3333, 0, 1'b0);
    txn(1'b0, 8'd0, '0, 0, 1'b0);
    chk("R6 no alias into reg 0", rdata, 64'h1111);
    txn(1'b0, 8'd16, '0, 2, 1'b0);
    chk("R6 oob read zero", rdata, 64'd0);

    // random traffic, mixed in-range and out-of-range
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      a = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(0, 255)) : AW'($urandom_range(0, NR - 1));
      txn($urandom_range(0, 1) == 1, a, {$urandom, $urandom}, $urandom_range(0, 3), 1'b1);
    end
    chk("R7 no err under compliant traffic", {63'd0, err}, 64'd0);

    // final readback of whole bank against model
    for (int i = 0; i < NR; i++) txn(1'b0, AW'(i), '0, 0, 1'b0);

    // R7: request in the cycle right after ack fell
    req = 1'b1; we = 1'b0; addr = 8'd5; wdata = '0;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk("R7 ack low in gap", {63'd0, ack}, 64'd0);
    chk("R7 err clear before violation", {63'd0, err}, 64'd0);
    req = 1'b1; addr = 8'd5;
    @(negedge clk);
    chk("R7 err set on gap request", {63'd0, err}, 64'd1);
    chk("R7 gap request not accepted", {63'd0, ack}, 64'd0);
    @(negedge clk);
    chk("R7 accepted one cycle later", {63'd0, ack}, 64'd1);
    chk("R7 late read data", rdata, model[5]);
    req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    txn(1'b0, 8'd1, '0, 1, 1'b0);
    chk("R7 err sticky", {63'd0, err}, 64'd1);

    // R8: reset clears flag and bank
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 err cleared", {63'd0, err}, 64'd0);
    chk("R8 rdata cleared", rdata, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NR; i++) model[i] = '0;
    txn(1'b0, 8'd5, '0, 0, 1'b0);
    chk("R8 reg cleared by reset", rdata, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule